// File: doc/BRIEF.md
# Nonvolatile Configuration Image Write Sequencer

This block programs a complete image of 16-bit words into a slow nonvolatile configuration memory. After a start request it raises a write-enable control bit and lets the memory settle. It then fetches each word from a local buffer by index and issues one single-cycle write strobe per word, with a fixed gap after every write. Finally it drops write-enable, waits again, and reports completion. All waits are counted in milliseconds by an internal prescaler, so the parameters can follow the clock rate of the host chip.

The sequencer shows that it is busy, counts the words written, pulses a milestone output at each quarter of the image, and pulses done at the end. If the image is flagged as having failed its CRC check, a start request is refused with a one-cycle reject pulse and the memory is left untouched. Start requests that arrive while a write is in progress are ignored.

Top module: `nvcfg_write_seq`

## Requirements
- R1: A start request (start_i high while idle with crc_bad_i low) sets we_ctl_o and busy_o from the next cycle on. The first write strobe comes only after we_ctl_o has been high for EN_MS*CLKS_PER_MS cycles, and no strobe ever occurs while we_ctl_o is low.
- R2: Words are written in ascending index order. The strobe for word k presents buf_idx_o = k, wr_data_o = buf_data_i and wr_addr_o = base + 2*k modulo 2^AW, where base is the value of base_addr_i sampled with the accepted start.
- R3: After each strobe the sequencer waits GAP_MS*CLKS_PER_MS cycles before the next strobe, so strobes are 1 + GAP_MS*CLKS_PER_MS cycles apart.
- R4: wr_stb_o is high for exactly one cycle per word, WORDS strobes per image.
- R5: After the gap that follows the last word, we_ctl_o is low and busy_o stays high for EN_MS*CLKS_PER_MS cycles. Then done_o pulses for one cycle, in the same cycle that busy_o falls.
- R6: A start request while idle with crc_bad_i high gives a one-cycle reject_o pulse in the next cycle. It raises neither busy_o nor we_ctl_o and leaves progress_o unchanged.
- R7: progress_o clears to 0 on an accepted start and rises by one in the cycle after each strobe. It holds WORDS after completion.
- R8: milestone_o pulses for one cycle together with the progress_o update that reaches WORDS/4, WORDS/2 or (3*WORDS)/4 (integer division).
- R9: start_i is ignored while busy_o is high, whatever the value of crc_bad_i. The timeline, the addresses and reject_o are unaffected.
- R10: After reset busy_o, we_ctl_o, wr_stb_o, done_o, milestone_o and reject_o are low, and progress_o and buf_idx_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to write the image |
| crc_bad_i | input | 1 | Image failed its CRC check |
| base_addr_i | input | AW | Byte address of word 0 |
| buf_idx_o | output | $clog2(WORDS) | Index of the word being fetched from the buffer |
| buf_data_i | input | DW | Buffer word at buf_idx_o |
| we_ctl_o | output | 1 | Memory write-enable control bit |
| wr_addr_o | output | AW | Byte address of the current word |
| wr_data_o | output | DW | Data of the current word |
| wr_stb_o | output | 1 | Single-cycle word write strobe |
| busy_o | output | 1 | Sequence in progress |
| progress_o | output | $clog2(WORDS+1) | Words written so far |
| milestone_o | output | 1 | Quarter-mark pulse |
| done_o | output | 1 | Completion pulse |
| reject_o | output | 1 | Start refused because of a bad CRC |

## Verification
If the start is sampled at edge 0, every output is a known function of the number of edges n that follow it. With T = EN_MS*CLKS_PER_MS and G = GAP_MS*CLKS_PER_MS, the strobe for word k is visible after edge T + k*(1+G), the matching progress and milestone update after the next edge, write-enable falls after edge T + WORDS*(1+G), and done appears after edge 2T + WORDS*(1+G). The bench counts edges from the accepted start and compares every output at the falling clock edge of every cycle against these formulas. A reject is due one edge after the refused request. Random start and CRC pulses are injected during a run to show that they change nothing.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_PUT,
    ST_GAP,
    ST_DISARM
  } nvw_state_e;
endpackage

// File: rtl/nvw_ms_timer.sv
module nvw_ms_timer #(
  parameter int CLKS_PER_MS = 100000,
  parameter int MSW         = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  logic [MSW-1:0] last_ms_i,
  output logic           expire_o
);
  localparam int PW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_MS - 1);

  logic [PW-1:0]  pre_q, pre_d;
  logic [MSW-1:0] ms_q, ms_d;
  logic           tick;

  always_comb begin
    tick     = run_i && (pre_q == PRE_LAST);
    expire_o = tick && (ms_q == last_ms_i);
    pre_d    = pre_q;
    ms_d     = ms_q;
    if (!run_i || expire_o) begin
      pre_d = '0;
      ms_d  = '0;
    end else if (tick) begin
      pre_d = '0;
      ms_d  = ms_q + MSW'(1);
    end else begin
      pre_d = pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else begin
      pre_q <= pre_d;
      ms_q  <= ms_d;
    end
  end

  // The millisecond count never passes the programmed limit
  AST_MS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (ms_q <= last_ms_i)); // R3
endmodule

// File: rtl/nvw_progress.sv
module nvw_progress #(
  parameter int WORDS = 64,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] count_o,
  output logic          milestone_o
);
  localparam logic [CW-1:0] Q1 = CW'(WORDS / 4);
  localparam logic [CW-1:0] Q2 = CW'(WORDS / 2);
  localparam logic [CW-1:0] Q3 = CW'((3 * WORDS) / 4);

  logic [CW-1:0] cnt_q, cnt_d, cnt_nx;
  logic          mile_q, mile_d;

  always_comb begin
    cnt_nx = cnt_q + CW'(1);
    cnt_d  = cnt_q;
    mile_d = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (inc_i) begin
      cnt_d  = cnt_nx;
      mile_d = (cnt_nx == Q1) || (cnt_nx == Q2) || (cnt_nx == Q3);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mile_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      mile_q <= mile_d;
    end
  end

  assign count_o     = cnt_q;
  assign milestone_o = mile_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CW'(WORDS)); // R7
  AST_MILE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |=> (count_o == $past(count_o) + CW'(1))); // R7
  AST_MILE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    milestone_o |=> !milestone_o); // R8
endmodule

// File: rtl/nvcfg_write_seq.sv
module nvcfg_write_seq #(
  parameter int WORDS       = 64,
  parameter int CLKS_PER_MS = 100000,
  parameter int EN_MS       = 500,
  parameter int GAP_MS      = 20,
  parameter int AW          = 16,
  parameter int DW          = 16,
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CW = $clog2(WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          crc_bad_i,
  input  logic [AW-1:0] base_addr_i,
  output logic [IW-1:0] buf_idx_o,
  input  logic [DW-1:0] buf_data_i,
  output logic          we_ctl_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          wr_stb_o,
  output logic          busy_o,
  output logic [CW-1:0] progress_o,
  output logic          milestone_o,
  output logic          done_o,
  output logic          reject_o
);
  import nvw_pkg::*;

  localparam int MAXMS = (EN_MS > GAP_MS) ? EN_MS : GAP_MS;
  localparam int MSW   = (MAXMS > 1) ? $clog2(MAXMS) : 1;
  localparam logic [MSW-1:0] EN_LAST  = MSW'(EN_MS - 1);
  localparam logic [MSW-1:0] GAP_LAST = MSW'(GAP_MS - 1);
  localparam logic [IW-1:0]  IDX_LAST = IW'(WORDS - 1);

  nvw_state_e     state_q, state_d;
  logic [IW-1:0]  idx_q, idx_d;
  logic [AW-1:0]  base_q;
  logic           done_q, done_d;
  logic           rej_q, rej_d;
  logic           accept;
  logic           tmr_run, tmr_exp;
  logic [MSW-1:0] tmr_last;

  nvw_ms_timer #(.CLKS_PER_MS(CLKS_PER_MS), .MSW(MSW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (tmr_run),
    .last_ms_i (tmr_last),
    .expire_o  (tmr_exp)
  );

  nvw_progress #(.WORDS(WORDS), .CW(CW)) u_prog (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (accept),
    .inc_i       (wr_stb_o),
    .count_o     (progress_o),
    .milestone_o (milestone_o)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    done_d   = 1'b0;
    rej_d    = 1'b0;
    accept   = 1'b0;
    tmr_run  = (state_q == ST_ARM) || (state_q == ST_GAP) || (state_q == ST_DISARM);
    tmr_last = (state_q == ST_GAP) ? GAP_LAST : EN_LAST;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i && !crc_bad_i) begin
          accept  = 1'b1;
          idx_d   = '0;
          state_d = ST_ARM;
        end else if (start_i) begin
          rej_d = 1'b1;
        end
      end
      ST_ARM:    if (tmr_exp) state_d = ST_PUT;
      ST_PUT:    state_d = ST_GAP;
      ST_GAP: begin
        if (tmr_exp) begin
          if (idx_q == IDX_LAST) begin
            state_d = ST_DISARM;
          end else begin
            idx_d   = idx_q + IW'(1);
            state_d = ST_PUT;
          end
        end
      end
      ST_DISARM: begin
        if (tmr_exp) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default:   state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
      rej_q   <= rej_d;
    end
  end

  // Base address, loaded only with an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (accept) begin
      base_q <= base_addr_i;
    end
  end

  assign buf_idx_o = idx_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign we_ctl_o  = (state_q == ST_ARM) || (state_q == ST_PUT) || (state_q == ST_GAP);
  assign wr_stb_o  = (state_q == ST_PUT);
  assign wr_addr_o = base_q + AW'({idx_q, 1'b0});
  assign wr_data_o = buf_data_i;
  assign done_o    = done_q;
  assign reject_o  = rej_q;

  AST_STB_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> we_ctl_o); // R1
  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o); // R4
  AST_IDX_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $changed(buf_idx_o)) |-> (buf_idx_o == $past(buf_idx_o) + IW'(1))); // R2
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !we_ctl_o && $past(busy_o))); // R5
  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |-> (!busy_o && !$past(busy_o))); // R6
  AST_BUSY_HOLDS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(base_q)); // R9
endmodule

// File: tb/nvcfg_write_seq_test.sv
module nvcfg_write_seq_test;
  localparam int W    = 64;
  localparam int CPM  = 2;
  localparam int ENMS = 500;
  localparam int GPMS = 20;
  localparam int AW   = 16;
  localparam int T    = ENMS * CPM;
  localparam int G    = GPMS * CPM;
  localparam int ENDN = 2 * T + W * (1 + G);

  logic          clk, rst_n, start_i, crc_bad_i;
  logic [AW-1:0] base_addr_i;
  logic [5:0]    buf_idx_o;
  logic [15:0]   buf_data_i;
  logic          we_ctl_o, wr_stb_o, busy_o, milestone_o, done_o, reject_o;
  logic [AW-1:0] wr_addr_o;
  logic [15:0]   wr_data_o;
  logic [6:0]    progress_o;
  logic [15:0]   img [W];

  int checks = 0;
  int errors = 0;

  assign buf_data_i = img[buf_idx_o];

  nvcfg_write_seq #(.WORDS(W), .CLKS_PER_MS(CPM), .EN_MS(ENMS), .GAP_MS(GPMS),
                    .AW(AW), .DW(16)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .crc_bad_i(crc_bad_i),
    .base_addr_i(base_addr_i), .buf_idx_o(buf_idx_o), .buf_data_i(buf_data_i),
    .we_ctl_o(we_ctl_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .wr_stb_o(wr_stb_o), .busy_o(busy_o), .progress_o(progress_o),
    .milestone_o(milestone_o), .done_o(done_o), .reject_o(reject_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      if (errors < 30) $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected values as functions of edges n since the accepted start
  function automatic bit in_write(int n);
    return (n >= T) && (n < T + W * (1 + G));
  endfunction
  function automatic int word_of(int n);
    return (n - T) / (1 + G);
  endfunction
  function automatic int phase_of(int n);
    return (n - T) % (1 + G);
  endfunction
  function automatic bit exp_we(int n);
    return n < T + W * (1 + G);
  endfunction
  function automatic bit exp_stb(int n);
    return in_write(n) && (phase_of(n) == 0);
  endfunction
  function automatic int exp_prog(int n);
    if (n < T) return 0;
    if (in_write(n)) return word_of(n) + ((phase_of(n) > 0) ? 1 : 0);
    return W;
  endfunction
  function automatic bit exp_mile(int n);
    int c;
    if (!in_write(n) || phase_of(n) != 1) return 1'b0;
    c = word_of(n) + 1;
    return (c == W / 4) || (c == W / 2) || (c == (3 * W) / 4);
  endfunction

  task automatic check_cycle(input int n, input logic [AW-1:0] b);
    int k;
    chk(busy_o == (n < ENDN), "R1/R5 busy", busy_o, (n < ENDN));
    chk(we_ctl_o == exp_we(n), "R1/R5 we_ctl", we_ctl_o, exp_we(n));
    chk(wr_stb_o == exp_stb(n), "R3/R4 strobe", wr_stb_o, exp_stb(n));
    chk(done_o == (n == ENDN), "R5 done", done_o, (n == ENDN));
    chk(progress_o == 7'(exp_prog(n)), "R7 progress", progress_o, exp_prog(n));
    chk(milestone_o == exp_mile(n), "R8 milestone", milestone_o, exp_mile(n));
    chk(reject_o == 1'b0, "R9 reject while busy", reject_o, 0);
    if (exp_stb(n)) begin
      k = word_of(n);
      chk(buf_idx_o == 6'(k), "R2 index", buf_idx_o, k);
      chk(wr_addr_o == AW'(b + AW'(2 * k)), "R2 address", wr_addr_o, AW'(b + AW'(2 * k)));
      chk(wr_data_o == img[k], "R2 data", wr_data_o, img[k]);
    end
  endtask

  task automatic run_image(input logic [AW-1:0] b, input bit noisy);
    foreach (img[i]) img[i] = 16'($urandom);
    @(negedge clk);
    start_i = 1'b1; crc_bad_i = 1'b0; base_addr_i = b;
    @(posedge clk);
    for (int n = 0; n <= ENDN + 1; n++) begin
      if (n > 0) @(posedge clk);
      @(negedge clk);
      if (n <= ENDN) check_cycle(n, b);
      else begin
        chk(!busy_o && !done_o && !we_ctl_o, "R5 idle after done", busy_o, 0);
        chk(progress_o == 7'(W), "R7 hold after done", progress_o, W);
      end
      // R9: random start/crc noise while busy, base changes ignored
      if (noisy && n < ENDN) begin
        start_i     = 1'($urandom);
        crc_bad_i   = 1'($urandom);
        base_addr_i = AW'($urandom);
      end else begin
        start_i = 1'b0; crc_bad_i = 1'b0;
      end
    end
  endtask

  task automatic try_reject();
    logic [6:0] p;
    p = progress_o;
    @(negedge clk);
    start_i = 1'b1; crc_bad_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; crc_bad_i = 1'b0;
    chk(reject_o == 1'b1, "R6 reject pulse", reject_o, 1);
    chk(!busy_o && !we_ctl_o, "R6 no busy on reject", busy_o, 0);
    chk(progress_o == p, "R6 progress kept", progress_o, p);
    @(negedge clk);
    chk(reject_o == 1'b0, "R6 reject one cycle", reject_o, 0);
    chk(!busy_o && !wr_stb_o, "R6 stays idle", busy_o, 0);
  endtask

  initial begin
    void'($urandom(32'd12345));
    rst_n = 1'b0; start_i = 1'b0; crc_bad_i = 1'b0; base_addr_i = '0;
    foreach (img[i]) img[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!busy_o && !we_ctl_o && !wr_stb_o, "R10 reset controls", {busy_o, we_ctl_o, wr_stb_o}, 0);
    chk(!done_o && !milestone_o && !reject_o, "R10 reset pulses", {done_o, milestone_o, reject_o}, 0);
    chk(progress_o == 0 && buf_idx_o == 0, "R10 reset counters", progress_o, 0);
    try_reject();
    run_image(16'h0100, 1'b0);
    try_reject();
    run_image(16'hFFF0, 1'b1);   // address wraps past the top
    run_image(AW'($urandom), 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule